// File: doc/BRIEF.md
# Reset Source and Sleep Controller

This block decides when the core of a small microcontroller is held in reset and when it is parked in a low-power sleep state. Four requests can reset the core: power-on, an active-low external pin, watchdog expiry and a low-supply (brown-out) indication. The block turns any accepted request into a registered core reset. It keeps a sticky 4-bit record of which sources fired. Software clears entries in that record by writing zeros.

A built-in watchdog counts clock cycles while it is enabled. Software restarts its period with a service strobe. When a sleep strobe arrives with the enable bit set in the 4-bit sleep control word and a supported mode code, the core is halted. An interrupt or any reset request wakes it. The core then stays halted for a start-up interval plus four more cycles. After an interrupt wake, a one-cycle resume pulse tells the core to continue at the instruction after the sleep instruction. After a reset wake, the core reset sends it to the reset vector, and no resume pulse is given.

All inputs are taken as synchronous to `clk`. The analog detectors and clock sources outside the block appear only as digital levels.

Top module: `rst_sleep_ctrl`

## Requirements
- R1: While `por_req` is high, `core_rst` is 1, `rst_flags` is 4'b0001 and `core_halt` is 0. A power-on request clears every other flag.
- R2: The external pin is accepted only after it has been sampled low on more than `EXT_MIN_CYC` consecutive clock edges. A shorter low pulse changes neither `core_rst` nor `rst_flags`.
- R3: With `wdt_en` high, the watchdog fires `WDT_PERIOD` edges after the last edge that sampled `wdt_kick`. A service strobe restarts the period. With `wdt_en` low, the watchdog never fires.
- R4: A brown-out reset occurs only while both `bod_low` and `bod_en` are high. `bod_low` alone has no effect.
- R5: `rst_flags` bit positions are: bit0 power-on, bit1 external pin, bit2 watchdog, bit3 brown-out. Each bit is set when its source is accepted. While `flag_wr` is high, a 0 in `flag_wdata` clears the matching bit and a 1 keeps it. A source firing in the same cycle wins over the clear.
- R6: `core_rst` is 1 in the cycle after any accepted source and returns to 0 in the cycle after no source is active.
- R7: `sleep_ctl` bit3 is the enable bit and bits[2:0] are the mode code. With the default mask, codes 0 to 4 are supported and 5 to 7 are not. A `sleep_req` with the enable bit set and a supported code halts the core from the next cycle. Any other `sleep_req` does nothing.
- R8: A `wake_irq` sampled while asleep keeps `core_halt` high for `STARTUP_CYC`+4 more cycles. `resume_next` then pulses for one cycle, in the first cycle with `core_halt` low. `wake_irq` has no effect while running.
- R9: A reset request while asleep asserts `core_rst` and wakes the core. `core_halt` stays high for the same interval as in R8, and `resume_next` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on request, active high; also resets the block |
| ext_rst_n | input | 1 | External reset pin, active low |
| bod_low | input | 1 | Low-supply indication from the detector |
| bod_en | input | 1 | Brown-out detection enable |
| wdt_en | input | 1 | Watchdog enable |
| wdt_kick | input | 1 | Watchdog service strobe |
| sleep_req | input | 1 | Sleep-instruction strobe |
| sleep_ctl | input | 4 | Bit3 sleep enable, bits[2:0] mode code |
| wake_irq | input | 1 | Interrupt wake request |
| flag_wr | input | 1 | Software write strobe for the reset flags |
| flag_wdata | input | 4 | Write data; 0 clears a flag, 1 keeps it |
| core_rst | output | 1 | Registered reset to the core |
| rst_flags | output | 4 | Sticky reset-cause flags |
| core_halt | output | 1 | Core gated while asleep or waking |
| resume_next | output | 1 | One-cycle pulse: continue after the sleep instruction |

## Verification
The hardest situation to reach from the ports is a reset request that arrives while the core is already asleep. The core must leave sleep through the full start-up and halt interval, and it must do so without the resume pulse that an interrupt wake would produce. The stimulus first parks the core with a valid sleep command, with the watchdog off so that nothing else can wake it. It then raises a gated brown-out for a single cycle and measures the halt length edge by edge. Randomised external pulse lengths, drawn on both sides of the minimum, and random control words cover acceptance of the pin and the decoding of the mode codes.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_WAKE} slp_state_e;
  typedef enum logic [0:0] {WAKE_BY_IRQ, WAKE_BY_RST} wake_kind_e;

  localparam int unsigned FLAG_N   = 4;
  localparam int unsigned FLAG_POR = 0;
  localparam int unsigned FLAG_EXT = 1;
  localparam int unsigned FLAG_WDT = 2;
  localparam int unsigned FLAG_BOD = 3;

  // A mode code is usable when its bit in the mask is set.
  function automatic logic mode_allowed(input logic [2:0] code, input logic [7:0] mask);
    return mask[code];
  endfunction

  // Write-zero-to-clear with set priority.
  function automatic logic [FLAG_N-1:0] flags_next(input logic [FLAG_N-1:0] cur,
                                                   input logic              wr,
                                                   input logic [FLAG_N-1:0] wdata,
                                                   input logic [FLAG_N-1:0] set);
    logic [FLAG_N-1:0] keep;
    keep = wr ? wdata : {FLAG_N{1'b1}};
    return (cur & keep) | set;
  endfunction

endpackage

// File: rtl/rsc_ext_filter.sv
module rsc_ext_filter #(
  parameter int unsigned MIN_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic hit
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_CYC);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
    end else if (pin_n) begin
      low_cnt <= '0;
    end else if (low_cnt != CNT_MAX) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign hit = !pin_n && (low_cnt == CNT_MAX);

  AST_EXT_PIN_WAS_LOW: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(!pin_n)); // R2

endmodule

// File: rtl/rsc_watchdog.sv
module rsc_watchdog #(
  parameter int unsigned PERIOD = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic kick,
  output logic fire
);
  localparam int unsigned CW = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] tick_cnt;

  assign fire = en && !kick && (tick_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en || kick || fire) begin
      tick_cnt <= '0;
    end else begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end

  AST_WDT_RESTARTS_AFTER_FIRE: assert property (@(posedge clk) disable iff (rst)
    fire |=> (tick_cnt == '0)); // R3

  AST_WDT_QUIET_AFTER_KICK: assert property (@(posedge clk) disable iff (rst)
    kick |=> !fire); // R3

endmodule

// File: rtl/rsc_cause.sv
module rsc_cause
  import rsc_pkg::*;
(
  input  logic              clk,
  input  logic              por,
  input  logic              ext_hit,
  input  logic              wdt_hit,
  input  logic              bod_hit,
  input  logic              wr,
  input  logic [FLAG_N-1:0] wdata,
  output logic [FLAG_N-1:0] flags,
  output logic              core_rst
);
  logic [FLAG_N-1:0] src_set;
  logic              any_src;

  always_comb begin
    src_set           = '0;
    src_set[FLAG_EXT] = ext_hit;
    src_set[FLAG_WDT] = wdt_hit;
    src_set[FLAG_BOD] = bod_hit;
  end

  assign any_src = |src_set;

  always_ff @(posedge clk) begin
    if (por) begin
      flags    <= FLAG_N'(1) << FLAG_POR;
      core_rst <= 1'b1;
    end else begin
      flags    <= flags_next(flags, wr, wdata, src_set);
      core_rst <= any_src;
    end
  end

  AST_RST_FOLLOWS_SOURCE: assert property (@(posedge clk) disable iff (por)
    any_src |=> core_rst); // R6

  AST_RST_RELEASES: assert property (@(posedge clk) disable iff (por)
    !any_src |=> !core_rst); // R6

  for (genvar i = 1; i < FLAG_N; i++) begin : g_flag_chk
    AST_FLAG_HAS_SOURCE: assert property (@(posedge clk) disable iff (por)
      $rose(flags[i]) |-> $past(src_set[i])); // R5
  end

endmodule

// File: rtl/rsc_sleep_fsm.sv
module rsc_sleep_fsm
  import rsc_pkg::*;
#(
  parameter int unsigned WAKE_LEN  = 12,
  parameter logic [7:0]  MODE_MASK = 8'h1F
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req,
  input  logic [3:0] sleep_ctl,
  input  logic       irq,
  input  logic       rst_evt,
  output logic       halt,
  output logic       resume
);
  localparam int unsigned WCW = $clog2(WAKE_LEN);
  localparam logic [WCW-1:0] WLAST = WCW'(WAKE_LEN - 1);

  slp_state_e     state;
  wake_kind_e     kind;
  logic [WCW-1:0] wcnt;

  logic mode_ok;
  logic enter_sleep;
  logic wake_evt;
  logic wake_done;

  assign mode_ok     = sleep_ctl[3] && mode_allowed(sleep_ctl[2:0], MODE_MASK);
  assign enter_sleep = (state == ST_RUN) && sleep_req && mode_ok && !rst_evt;
  assign wake_evt    = (state == ST_SLEEP) && (irq || rst_evt);
  assign wake_done   = (state == ST_WAKE) && (wcnt == WLAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_RUN;
      kind   <= WAKE_BY_IRQ;
      wcnt   <= '0;
      resume <= 1'b0;
    end else begin
      resume <= 1'b0;
      unique case (state)
        ST_RUN: begin
          if (enter_sleep) state <= ST_SLEEP;
        end
        ST_SLEEP: begin
          if (wake_evt) begin
            state <= ST_WAKE;
            wcnt  <= '0;
            kind  <= rst_evt ? WAKE_BY_RST : WAKE_BY_IRQ;
          end
        end
        ST_WAKE: begin
          if (rst_evt) kind <= WAKE_BY_RST;
          if (wake_done) begin
            state  <= ST_RUN;
            resume <= (kind == WAKE_BY_IRQ) && !rst_evt;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign halt = (state != ST_RUN);

  AST_BAD_MODE_NOOP: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_RUN) && sleep_req && !mode_ok) |=> !halt); // R7

  AST_SLEEP_KEEPS_HALT: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_SLEEP) && !irq && !rst_evt) |=> halt); // R8

  AST_RESUME_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    resume |-> ($past(halt) && !halt)); // R8

  AST_RESET_WAKE_NO_RESUME: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_WAKE) && (kind == WAKE_BY_RST)) |=> !resume); // R9

endmodule

// File: rtl/rst_sleep_ctrl.sv
module rst_sleep_ctrl
  import rsc_pkg::*;
#(
  parameter int unsigned EXT_MIN_CYC = 4,
  parameter int unsigned WDT_PERIOD  = 64,
  parameter int unsigned STARTUP_CYC = 8,
  parameter logic [7:0]  MODE_MASK   = 8'h1F
) (
  input  logic       clk,
  input  logic       por_req,
  input  logic       ext_rst_n,
  input  logic       bod_low,
  input  logic       bod_en,
  input  logic       wdt_en,
  input  logic       wdt_kick,
  input  logic       sleep_req,
  input  logic [3:0] sleep_ctl,
  input  logic       wake_irq,
  input  logic       flag_wr,
  input  logic [3:0] flag_wdata,
  output logic       core_rst,
  output logic [3:0] rst_flags,
  output logic       core_halt,
  output logic       resume_next
);
  localparam int unsigned WAKE_LEN = STARTUP_CYC + 4;

  logic ext_hit;
  logic wdt_hit;
  logic bod_hit;
  logic rst_evt;

  assign bod_hit = bod_low && bod_en;
  assign rst_evt = ext_hit || wdt_hit || bod_hit;

  rsc_ext_filter #(.MIN_CYC(EXT_MIN_CYC)) u_ext (
    .clk   (clk),
    .rst   (por_req),
    .pin_n (ext_rst_n),
    .hit   (ext_hit)
  );

  rsc_watchdog #(.PERIOD(WDT_PERIOD)) u_wdt (
    .clk  (clk),
    .rst  (por_req),
    .en   (wdt_en),
    .kick (wdt_kick),
    .fire (wdt_hit)
  );

  rsc_cause u_cause (
    .clk      (clk),
    .por      (por_req),
    .ext_hit  (ext_hit),
    .wdt_hit  (wdt_hit),
    .bod_hit  (bod_hit),
    .wr       (flag_wr),
    .wdata    (flag_wdata),
    .flags    (rst_flags),
    .core_rst (core_rst)
  );

  rsc_sleep_fsm #(.WAKE_LEN(WAKE_LEN), .MODE_MASK(MODE_MASK)) u_slp (
    .clk       (clk),
    .rst       (por_req),
    .sleep_req (sleep_req),
    .sleep_ctl (sleep_ctl),
    .irq       (wake_irq),
    .rst_evt   (rst_evt),
    .halt      (core_halt),
    .resume    (resume_next)
  );

  AST_BOD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (por_req)
    (!bod_en && !ext_hit && !wdt_hit) |=> !core_rst); // R4

  AST_IRQ_IGNORED_RUNNING: assert property (@(posedge clk) disable iff (por_req)
    (!core_halt && !sleep_req) |=> !core_halt); // R8

endmodule

// File: tb/rst_sleep_ctrl_bench.sv
module rst_sleep_ctrl_bench;
  localparam int unsigned P_EXT   = 4;
  localparam int unsigned P_WDT   = 64;
  localparam int unsigned P_START = 8;
  localparam int unsigned P_WAKE  = P_START + 4;
  localparam logic [7:0]  P_MASK  = 8'h1F;

  logic clk = 1'b0;
  logic por_req = 1'b1, ext_rst_n = 1'b1, bod_low = 1'b0, bod_en = 1'b0;
  logic wdt_en = 1'b0, wdt_kick = 1'b0, sleep_req = 1'b0, wake_irq = 1'b0;
  logic flag_wr = 1'b0;
  logic [3:0] sleep_ctl = 4'h0, flag_wdata = 4'h0;
  logic core_rst, core_halt, resume_next;
  logic [3:0] rst_flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rst_sleep_ctrl #(.EXT_MIN_CYC(P_EXT), .WDT_PERIOD(P_WDT),
                   .STARTUP_CYC(P_START), .MODE_MASK(P_MASK)) u_rst_sleep_ctrl (
    .clk(clk), .por_req(por_req), .ext_rst_n(ext_rst_n), .bod_low(bod_low),
    .bod_en(bod_en), .wdt_en(wdt_en), .wdt_kick(wdt_kick), .sleep_req(sleep_req),
    .sleep_ctl(sleep_ctl), .wake_irq(wake_irq), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .core_rst(core_rst), .rst_flags(rst_flags),
    .core_halt(core_halt), .resume_next(resume_next)
  );

  function automatic bit exp_ext_accept(input int len);
    return len > int'(P_EXT);
  endfunction

  function automatic bit exp_sleep_ok(input logic [3:0] ctl);
    return ctl[3] && (ctl[2:0] <= 3'd4) && P_MASK[ctl[2:0]];
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    flag_wr = 1'b1; flag_wdata = 4'h0; step(1);
    flag_wr = 1'b0; flag_wdata = 4'hF;
  endtask

  task automatic ext_pulse(input int len);
    ext_rst_n = 1'b0; step(len);
    ext_rst_n = 1'b1; step(1);
  endtask

  task automatic go_sleep(input logic [3:0] ctl);
    sleep_ctl = ctl; sleep_req = 1'b1; step(1);
    sleep_req = 1'b0;
  endtask

  task automatic irq_wake();
    wake_irq = 1'b1; step(1);
    wake_irq = 1'b0;
    chk("R8 halt right after irq", core_halt, 1);
    step(P_WAKE - 1);
    chk("R8 halt last wake cycle", core_halt, 1);
    chk("R8 no early resume", resume_next, 0);
    step(1);
    chk("R8 released", core_halt, 0);
    chk("R8 resume pulse", resume_next, 1);
    step(1);
    chk("R8 resume one cycle", resume_next, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    step(3);
    chk("R1 core_rst during por", core_rst, 1);
    chk("R1 flags during por", rst_flags, 4'b0001);
    chk("R1 not halted", core_halt, 0);
    por_req = 1'b0; step(1);
    chk("R6 release after por", core_rst, 0);
    chk("R1 por flag kept", rst_flags, 4'b0001);
    clear_flags();
    chk("R5 write zero clears", rst_flags, 4'b0000);

    // external pin, directed boundary
    ext_pulse(P_EXT);
    chk("R2 short pulse ignored", rst_flags[1], 0);
    ext_rst_n = 1'b0; step(P_EXT + 1);
    chk("R6 core_rst on long pulse", core_rst, 1);
    step(2); ext_rst_n = 1'b1; step(1);
    chk("R6 core_rst drops", core_rst, 0);
    chk("R2 long pulse flagged", rst_flags, 4'b0010);
    flag_wr = 1'b1; flag_wdata = 4'hF; step(1); flag_wr = 1'b0;
    chk("R5 write one keeps", rst_flags, 4'b0010);
    flag_wr = 1'b1; flag_wdata = 4'b1101; step(1); flag_wr = 1'b0;
    chk("R5 selective clear", rst_flags, 4'b0000);

    for (int i = 0; i < 12; i++) begin
      int len;
      len = $urandom_range(1, 2 * P_EXT + 2);
      ext_pulse(len);
      chk("R2 random pulse", rst_flags[1], exp_ext_accept(len));
      clear_flags();
    end

    // set wins over clear
    ext_rst_n = 1'b0; step(P_EXT);
    flag_wr = 1'b1; flag_wdata = 4'h0; step(1); flag_wr = 1'b0;
    ext_rst_n = 1'b1; step(1);
    chk("R5 set beats clear", rst_flags, 4'b0010);
    clear_flags();

    // brown-out
    bod_low = 1'b1; bod_en = 1'b0; step(5);
    chk("R4 disabled no reset", core_rst, 0);
    chk("R4 disabled no flag", rst_flags, 4'b0000);
    bod_en = 1'b1; step(1);
    chk("R4 enabled reset", core_rst, 1);
    chk("R4 bod flag", rst_flags, 4'b1000);
    bod_low = 1'b0; bod_en = 1'b0; step(1);
    chk("R6 bod release", core_rst, 0);
    clear_flags();

    // watchdog
    step(3 * P_WDT);
    chk("R3 disabled never fires", rst_flags, 4'b0000);
    wdt_en = 1'b1; wdt_kick = 1'b1; step(1); wdt_kick = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step($urandom_range(10, P_WDT - 2));
      wdt_kick = 1'b1; step(1); wdt_kick = 1'b0;
    end
    chk("R3 kicked in time", rst_flags, 4'b0000);
    step(P_WDT - 1);
    chk("R3 not yet expired", core_rst, 0);
    step(1);
    chk("R3 expiry resets", core_rst, 1);
    chk("R3 wdt flag", rst_flags, 4'b0100);
    wdt_en = 1'b0; step(1);
    chk("R6 wdt release", core_rst, 0);
    clear_flags();

    // sleep decode and interrupt wake
    wake_irq = 1'b1; step(3); wake_irq = 1'b0; step(1);
    chk("R8 irq while running ignored", core_halt, 0);
    chk("R8 no resume while running", resume_next, 0);
    for (int m = 0; m < 8; m++) begin
      go_sleep({1'b1, 3'(m)});
      chk("R7 mode decode", core_halt, exp_sleep_ok({1'b1, 3'(m)}));
      if (core_halt) irq_wake();
    end
    go_sleep(4'b0010);
    chk("R7 enable bit clear no-op", core_halt, 0);
    for (int i = 0; i < 16; i++) begin
      logic [3:0] c;
      c = 4'($urandom_range(0, 15));
      go_sleep(c);
      chk("R7 random control", core_halt, exp_sleep_ok(c));
      if (core_halt) irq_wake();
    end

    // reset wake
    go_sleep(4'b1000);
    step(5);
    chk("R8 stays asleep", core_halt, 1);
    bod_en = 1'b1; bod_low = 1'b1; step(1);
    bod_en = 1'b0; bod_low = 1'b0;
    chk("R9 reset asserted", core_rst, 1);
    chk("R9 halted", core_halt, 1);
    step(P_WAKE - 1);
    chk("R9 still halted", core_halt, 1);
    chk("R9 reset released", core_rst, 0);
    step(1);
    chk("R9 released", core_halt, 0);
    chk("R9 no resume", resume_next, 0);
    chk("R9 cause recorded", rst_flags, 4'b1000);

    // power-on clears other flags
    ext_pulse(P_EXT + 2);
    por_req = 1'b1; step(2);
    chk("R1 por clears others", rst_flags, 4'b0001);
    por_req = 1'b0; step(1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule